// File: doc/BRIEF.md
# Sampling Converter Cycle Sequencer

This block is the synchronous controller that runs the convert/acquire cycle of a two-pass sampling converter. It watches an active-low select and an active-low convert request, both brought into the clock domain through a flop chain. When a conversion starts it raises a busy/interrupt flag and drives four strobes into the analog datapath. These strobes are treated only as control pulses: hold the sample, run the first coarse pass, run the second fine pass, and capture the corrected result. When the conversion phase ends, busy falls and a fixed acquisition window follows. Once that window has passed, the sequencer waits for a new request.

A conversion starts on whichever of select and convert is asserted last. After a start, the sequencer finishes the conversion and the acquisition whatever its inputs do. If convert is still held low when acquisition ends, the next conversion begins at once, so a held request gives back-to-back conversions at the full rate. The result strobe fires in the final conversion cycle. The captured word is therefore ready just before busy falls and stays valid until busy next falls.

Top module: `adc_conv_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, all five outputs are low.
- R2: With `cs_n` low, a fall of `conv_n` starts a conversion. `busy_o` is first seen high after the third rising clock edge that follows the input change: two synchroniser stages and then the phase register.
- R3: Each conversion holds `busy_o` high for exactly `CONV_CYC` cycles (default 12). Busy then stays low for at least `ACQ_CYC` cycles (default 6).
- R4: `hold_o` is high on exactly the cycles on which `busy_o` is high.
- R5: In every conversion, `pass1_o` is a single-cycle pulse on conversion cycle `P1_AT` (default 2), and `pass2_o` is a single-cycle pulse on cycle `P2_AT` (default 7). Cycles are counted from 0 at the first busy cycle.
- R6: `latch_o` is a single-cycle pulse on the last conversion cycle. `busy_o` is low on the cycle that follows it.
- R7: A convert request that arrives and clears during a conversion or its acquisition window is ignored and starts nothing.
- R8: While `cs_n` and `conv_n` stay low, a new conversion begins right after each acquisition window. Busy is then low for exactly `ACQ_CYC` cycles between conversions.
- R9: While `cs_n` is high, no activity on `conv_n` starts a conversion.
- R10: If `conv_n` is already low when `cs_n` falls, the fall of `cs_n` starts the conversion, with the same latency as in R2.
- R11: After an acquisition window in which no request was pending, the sequencer stays idle with all outputs low until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Select, active low, asynchronous |
| conv_n | input | 1 | Convert request, active low, asynchronous |
| hold_o | output | 1 | Sample-and-hold in hold mode |
| pass1_o | output | 1 | Coarse flash pass strobe |
| pass2_o | output | 1 | Fine residue pass strobe |
| latch_o | output | 1 | Result capture strobe |
| busy_o | output | 1 | Conversion in progress; low during acquisition and idle |

## Verification
The stimulus includes a single short convert pulse, which fixes the start latency, the conversion and acquisition lengths, and the strobe positions within a conversion. It also includes extra pulses placed during the busy phase and during the acquisition window, which separate a design that ignores requests from one that queues them. A held request checks back-to-back timing and the exact number of conversions before release. Toggling convert while select is high, and lowering select after convert is already low, check the select gating and the last-arrival rule. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CONV = 2'd1,
    PH_ACQ  = 2'd2
  } phase_t;
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RST_VAL;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_seq_trig.sv
module adc_seq_trig (
  input  logic clk,
  input  logic rst,
  input  logic cs_s,
  input  logic conv_s,
  output logic req,
  output logic req_edge
);
  logic req_q;

  // request is the AND of both active-low inputs, so its rising edge
  // follows whichever of them arrived last
  assign req = ~cs_s & ~conv_s;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= req;
  end

  assign req_edge = req & ~req_q;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CONV_CYC = 12,
  parameter int ACQ_CYC  = 6,
  localparam int MAXC    = (CONV_CYC > ACQ_CYC) ? CONV_CYC : ACQ_CYC,
  localparam int CW      = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_edge,
  output phase_t        nxt_phase,
  output logic [CW-1:0] nxt_cnt
);
  localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CYC - 1);
  localparam logic [CW-1:0] ACQ_LAST  = CW'(ACQ_CYC - 1);

  phase_t        phase;
  logic [CW-1:0] cnt;

  always_comb begin
    nxt_phase = phase;
    nxt_cnt   = cnt;
    case (phase)
      PH_IDLE: begin
        if (req_edge) begin
          nxt_phase = PH_CONV;
          nxt_cnt   = '0;
        end
      end
      PH_CONV: begin
        if (cnt == CONV_LAST) begin
          nxt_phase = PH_ACQ;
          nxt_cnt   = '0;
        end else begin
          nxt_cnt = cnt + 1'b1;
        end
      end
      PH_ACQ: begin
        if (cnt == ACQ_LAST) begin
          nxt_phase = req ? PH_CONV : PH_IDLE;
          nxt_cnt   = '0;
        end else begin
          nxt_cnt = cnt + 1'b1;
        end
      end
      default: begin
        nxt_phase = PH_IDLE;
        nxt_cnt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= nxt_phase;
      cnt   <= nxt_cnt;
    end
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CONV_CYC    = 12,
  parameter int ACQ_CYC     = 6,
  parameter int P1_AT       = 2,
  parameter int P2_AT       = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic conv_n,
  output logic hold_o,
  output logic pass1_o,
  output logic pass2_o,
  output logic latch_o,
  output logic busy_o
);
  localparam int MAXC = (CONV_CYC > ACQ_CYC) ? CONV_CYC : ACQ_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] P1_IDX   = CW'(P1_AT);
  localparam logic [CW-1:0] P2_IDX   = CW'(P2_AT);
  localparam logic [CW-1:0] LAST_IDX = CW'(CONV_CYC - 1);

  logic          cs_s, conv_s, req, req_edge;
  phase_t        nxt_phase;
  logic [CW-1:0] nxt_cnt;
  logic          in_conv;

  adc_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst(rst), .d(cs_n), .q(cs_s)
  );
  adc_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_conv (
    .clk(clk), .rst(rst), .d(conv_n), .q(conv_s)
  );

  adc_seq_trig u_trig (
    .clk(clk), .rst(rst), .cs_s(cs_s), .conv_s(conv_s),
    .req(req), .req_edge(req_edge)
  );

  adc_seq_fsm #(.CONV_CYC(CONV_CYC), .ACQ_CYC(ACQ_CYC)) u_fsm (
    .clk(clk), .rst(rst), .req(req), .req_edge(req_edge),
    .nxt_phase(nxt_phase), .nxt_cnt(nxt_cnt)
  );

  assign in_conv = (nxt_phase == PH_CONV);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_o  <= 1'b0;
      pass1_o <= 1'b0;
      pass2_o <= 1'b0;
      latch_o <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      hold_o  <= in_conv;
      busy_o  <= in_conv;
      pass1_o <= in_conv && (nxt_cnt == P1_IDX);
      pass2_o <= in_conv && (nxt_cnt == P2_IDX);
      latch_o <= in_conv && (nxt_cnt == LAST_IDX);
    end
  end
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int CONV_CYC = 12,
  parameter int ACQ_CYC  = 6
) (
  input logic clk,
  input logic rst,
  input logic hold_o,
  input logic pass1_o,
  input logic pass2_o,
  input logic latch_o,
  input logic busy_o
);
  localparam int MAXC = (CONV_CYC > ACQ_CYC) ? CONV_CYC : ACQ_CYC;
  localparam int HW   = $clog2(MAXC + 2) + 1;

  logic [HW-1:0] hi_cnt, lo_cnt;

  // length of the current high run and of the current low run of busy
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      lo_cnt <= HW'(ACQ_CYC);
    end else if (busy_o) begin
      hi_cnt <= hi_cnt + 1'b1;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= '0;
      if (lo_cnt < HW'(ACQ_CYC)) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  p_hold_busy_r4: assert property (@(posedge clk) disable iff (rst)
    hold_o == busy_o);

  p_strobe_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pass1_o, pass2_o, latch_o}));

  p_pass1_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    pass1_o |=> !pass1_o);

  p_pass_in_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (pass1_o || pass2_o) |-> busy_o);

  p_latch_last_r6: assert property (@(posedge clk) disable iff (rst)
    latch_o |=> !busy_o);

  p_conv_len_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && hi_cnt != '0) |-> hi_cnt == HW'(CONV_CYC));

  p_acq_len_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && lo_cnt != '0) |-> lo_cnt >= HW'(ACQ_CYC));
endmodule

bind adc_conv_seq adc_conv_seq_chk #(.CONV_CYC(CONV_CYC), .ACQ_CYC(ACQ_CYC)) u_chk (
  .clk(clk), .rst(rst), .hold_o(hold_o), .pass1_o(pass1_o),
  .pass2_o(pass2_o), .latch_o(latch_o), .busy_o(busy_o)
);

// File: tb/sim_adc_conv_seq.sv
module sim_adc_conv_seq;
  localparam int CONV = 12;
  localparam int ACQ  = 6;
  localparam int P1   = 2;
  localparam int P2   = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic conv_n = 1'b1;
  logic hold_o, pass1_o, pass2_o, latch_o, busy_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_conv_seq #(.SYNC_STAGES(2), .CONV_CYC(CONV), .ACQ_CYC(ACQ),
                 .P1_AT(P1), .P2_AT(P2)) u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .conv_n(conv_n),
    .hold_o(hold_o), .pass1_o(pass1_o), .pass2_o(pass2_o),
    .latch_o(latch_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 converting, 2 acquiring
  bit m_cs1 = 1, m_cs2 = 1, m_cv1 = 1, m_cv2 = 1, m_reqq = 0;
  int m_ph = 0, m_cnt = 0;

  always @(posedge clk) begin
    bit rq, ed;
    rq = !m_cs2 && !m_cv2;
    ed = rq && !m_reqq;
    if (rst) begin
      m_cs1 = 1; m_cs2 = 1; m_cv1 = 1; m_cv2 = 1; m_reqq = 0;
      m_ph = 0; m_cnt = 0;
    end else begin
      if (m_ph == 0) begin
        if (ed) begin m_ph = 1; m_cnt = 0; end
      end else if (m_ph == 1) begin
        if (m_cnt == CONV - 1) begin m_ph = 2; m_cnt = 0; end
        else m_cnt++;
      end else begin
        if (m_cnt == ACQ - 1) begin m_ph = rq ? 1 : 0; m_cnt = 0; end
        else m_cnt++;
      end
      m_reqq = rq;
      m_cs2 = m_cs1; m_cs1 = cs_n;
      m_cv2 = m_cv1; m_cv1 = conv_n;
    end
  end

  // per-cycle compare plus run-length monitor
  int rises = 0, hirun = 0, lorun = 0, last_hi = 0, last_lo = 0;
  int p1pos = -1, p2pos = -1;
  bit pb = 0, pl = 0;

  always @(negedge clk) begin
    if (!rst) begin
      bit eb;
      eb = (m_ph == 1);
      chk(busy_o == eb, "R3 busy_o", busy_o, eb);
      chk(hold_o == eb, "R4 hold_o", hold_o, eb);
      chk(pass1_o == (eb && m_cnt == P1), "R5 pass1_o", pass1_o, eb && m_cnt == P1);
      chk(pass2_o == (eb && m_cnt == P2), "R5 pass2_o", pass2_o, eb && m_cnt == P2);
      chk(latch_o == (eb && m_cnt == CONV - 1), "R6 latch_o", latch_o, eb && m_cnt == CONV - 1);
      if (busy_o && !pb) begin rises++; last_lo = lorun; lorun = 0; end
      if (!busy_o && pb) begin
        last_hi = hirun; hirun = 0;
        chk(pl == 1'b1, "R6 latch before busy fall", pl, 1);
      end
      if (busy_o) begin
        if (pass1_o) p1pos = hirun;
        if (pass2_o) p2pos = hirun;
        hirun++;
      end else lorun++;
      pb = busy_o;
      pl = latch_o;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  initial begin
    int r0;
    repeat (5) step();
    chk({hold_o, pass1_o, pass2_o, latch_o, busy_o} == 5'b0, "R1 in reset",
        {hold_o, pass1_o, pass2_o, latch_o, busy_o}, 0);
    rst = 1'b0;
    step();
    chk({hold_o, pass1_o, pass2_o, latch_o, busy_o} == 5'b0, "R1 after reset",
        {hold_o, pass1_o, pass2_o, latch_o, busy_o}, 0);

    // single shot
    cs_n = 1'b0;
    repeat (4) step();
    r0 = rises;
    conv_n = 1'b0;
    repeat (2) step();
    chk(busy_o == 1'b0, "R2 busy before third edge", busy_o, 0);
    step();
    chk(busy_o == 1'b1, "R2 busy at third edge", busy_o, 1);
    step();
    conv_n = 1'b1;
    repeat (30) step();
    chk(rises == r0 + 1, "R2 one conversion", rises - r0, 1);
    chk(last_hi == CONV, "R3 busy high length", last_hi, CONV);
    chk(p1pos == P1, "R5 pass1 position", p1pos, P1);
    chk(p2pos == P2, "R5 pass2 position", p2pos, P2);
    repeat (20) step();
    chk(busy_o == 1'b0 && rises == r0 + 1, "R11 stays idle", rises - r0, 1);

    // requests during conversion and acquisition
    r0 = rises;
    conv_n = 1'b0;
    repeat (3) step();
    conv_n = 1'b1;
    repeat (3) step();
    conv_n = 1'b0;
    step();
    conv_n = 1'b1;
    while (busy_o) step();
    step();
    conv_n = 1'b0;
    step();
    conv_n = 1'b1;
    repeat (40) step();
    chk(rises == r0 + 1, "R7 mid-cycle requests ignored", rises - r0, 1);

    // continuous mode
    r0 = rises;
    conv_n = 1'b0;
    repeat (80) step();
    conv_n = 1'b1;
    repeat (40) step();
    chk(rises - r0 == 5, "R8 conversion count", rises - r0, 5);
    chk(last_lo == ACQ, "R8 acquire gap", last_lo, ACQ);
    chk(last_hi == CONV, "R3 busy length in continuous", last_hi, CONV);

    // select high blocks conversion
    r0 = rises;
    cs_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      conv_n = 1'b0; repeat (3) step();
      conv_n = 1'b1; repeat (5) step();
    end
    chk(rises == r0 && busy_o == 1'b0, "R9 no start without select", rises - r0, 0);

    // select arrives last
    conv_n = 1'b0;
    repeat (5) step();
    r0 = rises;
    cs_n = 1'b0;
    repeat (2) step();
    chk(busy_o == 1'b0, "R10 busy before third edge", busy_o, 0);
    step();
    chk(busy_o == 1'b1, "R10 start on select fall", busy_o, 1);
    conv_n = 1'b1;
    repeat (30) step();
    chk(rises == r0 + 1, "R10 one conversion", rises - r0, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule